// File: doc/BRIEF.md
# Deferred Auto-Refresh Scheduler and Bus Arbiter

This block times periodic auto-refresh operations for a dynamic memory controller and also decides which of three masters owns the shared memory bus. The three masters are a display fetch engine, the internal refresh engine and a processor. A free-running interval counter expires once per programmed refresh period. Each expiry adds one refresh to a pending tally. The refresh engine asks for the bus whenever that tally is nonzero.

Ownership is never taken away from a master while it still requests the bus. If the display engine keeps the bus across several refresh periods, the expiries that fall inside that time only raise the tally. Once the display engine lets go, the owed refreshes are issued one after another, each started by a one-cycle command strobe and ended by a done pulse from the memory side. The processor gets the bus only when nothing is owed.

The arbiter returns the bus to the processor, or leaves it free, after the last owed refresh completes. Command timing, address multiplexing and the data path belong to the surrounding controller.

Top module: `refresh_arbiter`

## Requirements
- R1: The interval select code picks the refresh period in clock cycles: 0→47, 1→78, 2→156, 3→312, 4→468, 5→624, 6→936, 7→1248. With the bus otherwise idle, consecutive rising edges of `ref_cmd` are exactly that many cycles apart.
- R2: A new select code does not cut short the period already running. The period in progress keeps its old length, and the new length applies from the next expiry onward.
- R3: The pending tally is 4 bits wide and stops at 15 instead of wrapping. If 20 periods expire while the display engine holds the bus, exactly 15 refreshes are replayed afterwards.
- R4: While the display engine is granted and still requesting, no refresh command is issued. Every expiry in that time is added to the tally.
- R5: After the bus is released, every owed refresh is issued before the processor is granted. Each refresh keeps the refresh grant until its `ref_done`. The next command follows in the cycle after that done, so n owed refreshes, with done returned one cycle after each command, take 2n cycles before the processor is granted.
- R6: When the owner releases the bus or the bus is free, the next owner is chosen by fixed priority: display engine, then refresh (tally nonzero), then processor.
- R7: A display or processor owner keeps its grant for as long as it keeps requesting, even when higher-priority requests or expiries arrive.
- R8: During reset and directly after it, no grant and no command are active. The first `ref_cmd` appears 47 cycles after reset release for select code 0.
- R9: `gnt` is one-hot or zero (bit 2 display, bit 1 refresh, bit 0 processor). `ref_cmd` is high only together with `gnt[1]`.
- R10: A `ref_done` pulse that arrives while refresh is not granted is ignored and does not reduce the tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ivl_sel | input | 3 | Refresh period select code |
| req_disp | input | 1 | Bus request from the display fetch engine |
| req_cpu | input | 1 | Bus request from the processor |
| ref_done | input | 1 | Memory side reports the current refresh finished |
| gnt | output | 3 | One-hot grant: bit 2 display, bit 1 refresh, bit 0 processor |
| ref_cmd | output | 1 | One-cycle strobe starting each refresh |

## Verification
Grants and the command strobe are registered, so a request or done seen at one rising edge shows up after that edge. The bench drives inputs at the falling edge and samples outputs there. An expiry in the cycle before edge E makes `ref_cmd` visible at the falling edge after E. Periods are therefore measured as counts of falling edges between strobes, and the first strobe after reset is expected on the 47th falling edge. Deferral windows are timed from a synchronising strobe so that each expected tally and each 2n-cycle burst length is computed by arithmetic.

// File: rtl/refresh_arbiter.sv
module refresh_arbiter #(
  parameter int PEND_W = 4,
  parameter int CNT_W  = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ivl_sel,
  input  logic       req_disp,
  input  logic       req_cpu,
  input  logic       ref_done,
  output logic [2:0] gnt,
  output logic       ref_cmd
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  typedef enum logic [1:0] {OWN_NONE, OWN_CPU, OWN_REF, OWN_DISP} owner_t;

  function automatic logic [CNT_W-1:0] ivl_len(input logic [2:0] s);
    case (s)
      3'd0:    ivl_len = CNT_W'(47);
      3'd1:    ivl_len = CNT_W'(78);
      3'd2:    ivl_len = CNT_W'(156);
      3'd3:    ivl_len = CNT_W'(312);
      3'd4:    ivl_len = CNT_W'(468);
      3'd5:    ivl_len = CNT_W'(624);
      3'd6:    ivl_len = CNT_W'(936);
      default: ivl_len = CNT_W'(1248);
    endcase
  endfunction

  logic [CNT_W-1:0]  cnt;
  logic [PEND_W-1:0] pend, pend_nx;
  owner_t            own, own_nx;
  logic              keep;

  wire tick    = (cnt == '0);
  wire done_ok = (own == OWN_REF) && ref_done;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= ivl_len(ivl_sel) - CNT_W'(1);
    else if (tick) cnt <= ivl_len(ivl_sel) - CNT_W'(1);
    else           cnt <= cnt - CNT_W'(1);
  end

  always_comb begin
    pend_nx = pend;
    if (tick && !done_ok && pend != PEND_MAX)
      pend_nx = pend + PEND_W'(1);
    else if (done_ok && !tick && pend != '0)
      pend_nx = pend - PEND_W'(1);
  end

  assign keep = ((own == OWN_DISP) && req_disp) ||
                ((own == OWN_CPU)  && req_cpu)  ||
                ((own == OWN_REF)  && !ref_done);

  always_comb begin
    if (keep)                 own_nx = own;
    else if (req_disp)        own_nx = OWN_DISP;
    else if (pend_nx != '0)   own_nx = OWN_REF;
    else if (req_cpu)         own_nx = OWN_CPU;
    else                      own_nx = OWN_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      own     <= OWN_NONE;
      ref_cmd <= 1'b0;
    end else begin
      pend    <= pend_nx;
      own     <= own_nx;
      ref_cmd <= (own_nx == OWN_REF) && ((own != OWN_REF) || ref_done);
    end
  end

  assign gnt = {own == OWN_DISP, own == OWN_REF, own == OWN_CPU};

endmodule

module refresh_arbiter_chk #(
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_disp,
  input logic              req_cpu,
  input logic              ref_done,
  input logic [2:0]        gnt,
  input logic              ref_cmd,
  input logic [PEND_W-1:0] pend,
  input logic              tick
);
  localparam logic [PEND_W-1:0] PMAX = '1;

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_cmd_grant_r9: assert property (@(posedge clk) disable iff (!rst_n) ref_cmd |-> gnt[1]);
  p_hold_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 3'b001 && req_cpu) |=> gnt == 3'b001);
  p_hold_disp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 3'b100 && req_disp) |=> gnt == 3'b100);
  p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[2] && req_disp) |=> !ref_cmd);
  p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[1] && !ref_done) |=> (gnt[1] && !ref_cmd));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == PMAX && tick && !(gnt[1] && ref_done)) |=> pend == PMAX);
  p_free_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 3'b000 && req_disp) |=> gnt[2]);
endmodule

bind refresh_arbiter refresh_arbiter_chk #(.PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_disp(req_disp), .req_cpu(req_cpu),
  .ref_done(ref_done), .gnt(gnt), .ref_cmd(ref_cmd), .pend(pend), .tick(tick)
);

// File: tb/test_refresh_arbiter.sv
module test_refresh_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ivl_sel = 3'd0;
  logic       req_disp = 1'b0;
  logic       req_cpu = 1'b0;
  logic       ref_done = 1'b0;
  logic       junk_done = 1'b0;
  logic [2:0] gnt;
  logic       ref_cmd;

  int checks = 0;
  int errors = 0;
  int bad_r9 = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  refresh_arbiter i_refresh_arbiter (
    .clk(clk), .rst_n(rst_n), .ivl_sel(ivl_sel), .req_disp(req_disp),
    .req_cpu(req_cpu), .ref_done(ref_done), .gnt(gnt), .ref_cmd(ref_cmd)
  );

  always begin
    @(negedge clk);
    #2;
    ref_done = (gnt[1] && !ref_done) || junk_done;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!(gnt == 3'b000 || gnt == 3'b001 || gnt == 3'b010 || gnt == 3'b100)) bad_r9++;
      if (ref_cmd && !gnt[1]) bad_r9++;
    end
  end

  function automatic int period(input int s);
    if (s == 0) return 47;
    if (s == 1) return 78;
    if (s <= 5) return 156 * (s - 1);
    return 156 * (2 * s - 6);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cmd(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ref_cmd && n < 3000);
  endtask

  task automatic defer(input int k);
    int n, win, cyc;
    wait_cmd(n);
    req_disp = 1'b1;
    req_cpu  = 1'b1;
    win = 0;
    repeat (47 * k + 2) begin
      @(negedge clk);
      if (ref_cmd) win++;
    end
    check("R4 commands while display holds", win, 0);
    check("R6 display over processor", int'(gnt), 4);
    req_disp = 1'b0;
    n = 0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (ref_cmd) n++;
    end while (!gnt[0] && cyc < 300);
    check("R3 replayed refreshes", n, (k > 15) ? 15 : k);
    check("R5 burst cycles before processor", cyc, 2 * ((k > 15) ? 15 : k));
    req_cpu = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n, prev, badg, cmds, cyc;
    repeat (3) @(negedge clk);
    check("R8 grant in reset", int'(gnt), 0);
    check("R8 command in reset", int'(ref_cmd), 0);
    rst_n = 1'b1;
    wait_cmd(n);
    check("R8 first command after reset", n, 47);

    prev = 0;
    for (int s = 0; s < 8; s++) begin
      ivl_sel = 3'(s);
      wait_cmd(n);
      check("R2 old period runs out", n, period(prev));
      wait_cmd(n);
      check("R1 period for select code", n, period(s));
      prev = s;
    end

    ivl_sel = 3'd0;
    wait_cmd(n);
    defer(1);
    defer(3);
    defer(15);
    defer(20);

    wait_cmd(n);
    req_cpu = 1'b1;
    badg = 0;
    cmds = 0;
    for (int i = 0; i < 47 * 3 + 2; i++) begin
      @(negedge clk);
      if (i > 0 && gnt != 3'b001) badg++;
      if (ref_cmd) cmds++;
      req_disp  = (i >= 60 && i < 70);
      junk_done = (i == 80 || i == 100);
    end
    junk_done = 1'b0;
    check("R7 processor keeps grant", badg, 0);
    check("R7 no refresh during processor hold", cmds, 0);
    req_cpu  = 1'b0;
    req_disp = 1'b1;
    @(negedge clk);
    check("R6 display chosen before owed refresh", int'(gnt), 4);
    repeat (4) @(negedge clk);
    req_disp = 1'b0;
    cmds = 0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (ref_cmd) cmds++;
    end while (gnt != 3'b000 && cyc < 100);
    check("R10 stray done ignored, owed count", cmds, 3);
    check("R9 grant encoding and strobe", bad_r9, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule